// File: doc/BRIEF.md
# Packed Lane Shifter

A 128-bit shifter that views its operand as sixteen bytes, eight halfwords, four words or two doublewords, chosen by a lane-size select, and moves every lane by one shared count. Each lane can be shifted left with zero fill, shifted right with zero fill, or shifted right with sign fill. Bits never cross a lane boundary, and no carry or flag is produced. A second family of operations moves the whole 128-bit operand left or right by a count of bytes.

Byte lanes are built by shifting the full word once and then clearing the bits that leaked in from the neighbouring byte with a replicated per-count mask. A clip control decides what happens to byte lanes when the count reaches eight or more: it either uses only the low three count bits, or it saturates the lanes to zero. One register stage sits between the request and the result, qualified by a valid bit in each direction.

Top module: `plshf_top`

## Requirements
- R1: While reset is held, and after it until the first accepted request, out_valid, out_data and out_illegal are all zero.
- R2: A request with in_valid high appears on out_data and out_illegal one clock later with out_valid high; when in_valid is low, out_valid is low one clock later and out_data and out_illegal keep their values.
- R3: in_lane selects the lane width (0 = 8, 1 = 16, 2 = 32, 3 = 64 bits); in_op 0 shifts each lane left, loading zeros at the lane LSB and dropping bits off the lane MSB without disturbing the next lane.
- R4: in_op 1 shifts each lane right, loading zeros at the lane MSB.
- R5: in_op 2 shifts each 16-bit or 32-bit lane right, copying the lane sign bit into the vacated MSB positions.
- R6: For in_op 0 or 1 with a count of at least the lane width, the lane becomes zero (for byte lanes this holds only when in_clip is 0).
- R7: For in_op 2 with a count of at least the lane width, every bit of the lane equals its original sign bit.
- R8: With byte lanes and in_clip = 1, only the low three bits of the count are used (a count of 9 shifts by 1, a count of 8 leaves the data unchanged); in_clip has no effect for wider lanes.
- R9: in_op 3 shifts the whole 128-bit operand left and in_op 4 shifts it right by in_count bytes with zero fill, ignoring in_lane; a count of 16 or more gives zero.
- R10: in_op 2 with 8-bit or 64-bit lanes, and any in_op of 5 to 7, is illegal: out_illegal is 1 and out_data equals in_data.
- R11: A legal request with a count of zero returns in_data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_data | input | 128 | Operand |
| in_lane | input | 2 | Lane width select |
| in_op | input | 3 | Operation select |
| in_count | input | 8 | Shift count, bits for lane ops, bytes for whole-operand ops |
| in_clip | input | 1 | Byte-lane count handling: 1 clip to 3 bits, 0 saturate |
| out_valid | output | 1 | Result present this cycle |
| out_data | output | 128 | Shifted result |
| out_illegal | output | 1 | The request that produced out_data was illegal |

## Verification
The assertions watch on every cycle the valid pipeline and the holding of the result while idle, the pass-through of illegal requests, identity at count zero, and the saturation cases where a logical shift or a whole-operand byte shift must yield zero and an over-range word shift must yield sign fill. The actual movement of bits inside each lane, the lane isolation at every width, the clip-versus-saturate choice for byte lanes and the byte-granular whole-operand moves can only be shown by the bench's scenarios, which compare every output bit against a bit-position model written independently of the RTL.

// File: rtl/plshf_pkg.sv
package plshf_pkg;

  typedef enum logic [2:0] {
    OP_SLL = 3'd0,
    OP_SRL = 3'd1,
    OP_SRA = 3'd2,
    OP_BSL = 3'd3,
    OP_BSR = 3'd4
  } shf_op_e;

  typedef enum logic [1:0] {
    LANE_8  = 2'd0,
    LANE_16 = 2'd1,
    LANE_32 = 2'd2,
    LANE_64 = 2'd3
  } lane_sel_e;

  // Bits of one byte that survive a shift by c inside that byte.
  function automatic logic [7:0] byte_keep_mask(input logic right, input logic [2:0] c);
    return right ? (8'hFF >> c) : (8'hFF << c);
  endfunction

  // Requests the datapath does not support.
  function automatic logic op_is_illegal(input logic [2:0] op, input logic [1:0] lane);
    logic bad_code, bad_arith;
    bad_code  = (op > OP_BSR);
    bad_arith = (op == OP_SRA) && ((lane == LANE_8) || (lane == LANE_64));
    return bad_code || bad_arith;
  endfunction

endpackage

// File: rtl/plshf_byte_lanes.sv
module plshf_byte_lanes
  import plshf_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 8
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              right,
  input  logic              clip,
  output logic [DATA_W-1:0] dout,
  output logic              over_range
);
  localparam int NB = DATA_W / 8;

  logic [2:0]        c3;
  logic [DATA_W-1:0] wide;
  logic [DATA_W-1:0] keep;

  assign c3         = cnt[2:0];
  assign over_range = !clip && (|cnt[CNT_W-1:3]);
  assign wide       = right ? (din >> c3) : (din << c3);
  assign keep       = {NB{byte_keep_mask(right, c3)}};
  assign dout       = over_range ? '0 : (wide & keep);
endmodule

// File: rtl/plshf_lane_array.sv
module plshf_lane_array
  import plshf_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int LANE_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  cnt,
  input  shf_op_e           op,
  output logic [DATA_W-1:0] dout,
  output logic              over_range
);
  localparam int NL      = DATA_W / LANE_W;
  localparam int LW_BITS = $clog2(LANE_W);

  logic [LW_BITS-1:0] c;

  assign c          = cnt[LW_BITS-1:0];
  assign over_range = (cnt >= CNT_W'(LANE_W));

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [LANE_W-1:0] lane_in;
    logic [LANE_W-1:0] lane_out;

    assign lane_in = din[g*LANE_W +: LANE_W];

    always_comb begin
      case (op)
        OP_SLL:  lane_out = over_range ? '0 : (lane_in << c);
        OP_SRL:  lane_out = over_range ? '0 : (lane_in >> c);
        OP_SRA:  lane_out = over_range ? {LANE_W{lane_in[LANE_W-1]}}
                                       : LANE_W'($signed(lane_in) >>> c);
        default: lane_out = lane_in;
      endcase
    end

    assign dout[g*LANE_W +: LANE_W] = lane_out;
  end
endmodule

// File: rtl/plshf_reg_bytes.sv
module plshf_reg_bytes #(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 8
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              right,
  output logic [DATA_W-1:0] dout,
  output logic              over_range
);
  localparam int NB      = DATA_W / 8;
  localparam int NB_BITS = $clog2(NB);

  logic [NB_BITS+2:0] bit_sh;

  assign over_range = (cnt >= CNT_W'(NB));
  assign bit_sh     = {cnt[NB_BITS-1:0], 3'b000};
  assign dout       = over_range ? '0 : (right ? (din >> bit_sh) : (din << bit_sh));
endmodule

// File: rtl/plshf_top.sv
module plshf_top
  import plshf_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [1:0]        in_lane,
  input  logic [2:0]        in_op,
  input  logic [CNT_W-1:0]  in_count,
  input  logic              in_clip,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_illegal
);
  localparam int NSIZES = 4;

  shf_op_e           op_t;
  logic              illegal_req;
  logic              whole_req;
  logic [DATA_W-1:0] lane_res [NSIZES];
  logic [NSIZES-1:0] lane_over;
  logic [DATA_W-1:0] reg_res;
  logic              reg_over;
  logic [DATA_W-1:0] nxt_data;

  assign op_t        = shf_op_e'(in_op);
  assign illegal_req = op_is_illegal(in_op, in_lane);
  assign whole_req   = (op_t == OP_BSL) || (op_t == OP_BSR);

  plshf_byte_lanes #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_bytes (
    .din        (in_data),
    .cnt        (in_count),
    .right      (op_t == OP_SRL),
    .clip       (in_clip),
    .dout       (lane_res[0]),
    .over_range (lane_over[0])
  );

  for (genvar k = 1; k < NSIZES; k++) begin : g_size
    plshf_lane_array #(.DATA_W(DATA_W), .LANE_W(8 << k), .CNT_W(CNT_W)) u_lanes (
      .din        (in_data),
      .cnt        (in_count),
      .op         (op_t),
      .dout       (lane_res[k]),
      .over_range (lane_over[k])
    );
  end

  plshf_reg_bytes #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_whole (
    .din        (in_data),
    .cnt        (in_count),
    .right      (op_t == OP_BSR),
    .dout       (reg_res),
    .over_range (reg_over)
  );

  always_comb begin
    if (illegal_req)    nxt_data = in_data;
    else if (whole_req) nxt_data = reg_res;
    else                nxt_data = lane_res[in_lane];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data    <= nxt_data;
        out_illegal <= illegal_req;
      end
    end
  end
endmodule

// File: rtl/plshf_chk.sv
module plshf_chk #(
  parameter int DATA_W = 128,
  parameter int CNT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic [1:0]        in_lane,
  input logic [2:0]        in_op,
  input logic [CNT_W-1:0]  in_count,
  input logic              in_clip,
  input logic              illegal_req,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_illegal
);
  logic logic_op, whole_op, byte_clip;
  assign logic_op  = (in_op == 3'd0) || (in_op == 3'd1);
  assign whole_op  = (in_op == 3'd3) || (in_op == 3'd4);
  assign byte_clip = (in_lane == 2'd0) && in_clip;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);  // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);  // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_data) && $stable(out_illegal)));  // R2
  AST_ILLEGAL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && illegal_req) |=> (out_illegal && out_data == $past(in_data)));  // R10
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !illegal_req && in_count == '0) |=> (out_data == $past(in_data)));  // R11
  AST_LOGIC_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && logic_op && in_count >= CNT_W'(64) && !byte_clip) |=> (out_data == '0));  // R6
  AST_SRA_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op == 3'd2 && in_lane == 2'd2 && in_count >= CNT_W'(32))
    |=> (out_data[31:0] == {32{$past(in_data[31])}}));  // R7
  AST_WHOLE_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && whole_op && in_count >= CNT_W'(16)) |=> (out_data == '0));  // R9
endmodule

bind plshf_top plshf_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_plshf_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_data     (in_data),
  .in_lane     (in_lane),
  .in_op       (in_op),
  .in_count    (in_count),
  .in_clip     (in_clip),
  .illegal_req (illegal_req),
  .out_valid   (out_valid),
  .out_data    (out_data),
  .out_illegal (out_illegal)
);

// File: tb/test_plshf_top.sv
module test_plshf_top;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] in_data = '0;
  logic [1:0]   in_lane = '0;
  logic [2:0]   in_op = '0;
  logic [7:0]   in_count = '0;
  logic         in_clip = 1'b0;
  logic         out_valid;
  logic [127:0] out_data;
  logic         out_illegal;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  plshf_top i_plshf_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_lane(in_lane), .in_op(in_op), .in_count(in_count), .in_clip(in_clip),
    .out_valid(out_valid), .out_data(out_data), .out_illegal(out_illegal)
  );

  localparam logic [127:0] D1 = 128'h0123456789ABCDEF_FEDCBA9876543210;
  localparam logic [127:0] D2 = 128'h80007FFFF00F0FF0_84211248C3C33C3C;

  localparam logic [127:0] T_DATA  [NT] = '{D1, D1, D2, D2, D1, D2, D1, D2, D1, D2};
  localparam logic [2:0]   T_OP    [NT] = '{3'd0, 3'd1, 3'd2, 3'd1, 3'd0, 3'd2, 3'd3, 3'd4, 3'd6, 3'd1};
  localparam logic [7:0]   T_COUNT [NT] = '{8'd3, 8'd5, 8'd7, 8'd12, 8'd20, 8'd33, 8'd5, 8'd15, 8'd2, 8'd70};
  localparam logic         T_CLIP  [NT] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0};

  // Bit-position model: each output bit names the input bit it comes from.
  function automatic logic [128:0] model(input logic [127:0] d, input int lane,
                                         input int op, input int cnt, input bit clip);
    logic [127:0] r;
    int w, c, b, p, src;
    w = 8 << lane;
    if (op > 4 || (op == 2 && (lane == 0 || lane == 3))) return {1'b1, d};
    c = (lane == 0 && clip) ? (cnt % 8) : cnt;
    for (int i = 0; i < 128; i++) begin
      b = (i / w) * w;
      p = i - b;
      case (op)
        0: r[i] = (c < w && p >= c) ? d[b + p - c] : 1'b0;
        1: r[i] = (p + c < w) ? d[b + p + c] : 1'b0;
        2: r[i] = (p + c < w) ? d[b + p + c] : d[b + w - 1];
        3: begin src = i - 8 * cnt; r[i] = (cnt < 16 && src >= 0) ? d[src] : 1'b0; end
        default: begin src = i + 8 * cnt; r[i] = (src < 128) ? d[src] : 1'b0; end
      endcase
    end
    return {1'b0, r};
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [127:0] d, input logic [1:0] lane, input logic [2:0] op,
                       input logic [7:0] cnt, input logic clip);
    @(negedge clk);
    in_data = d; in_lane = lane; in_op = op; in_count = cnt; in_clip = clip;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [128:0] m;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1", {126'd0, out_valid, out_illegal}, 128'd0);
    check("R1", out_data, 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {126'd0, out_valid, out_illegal}, 128'd0);

    // Table walk over every lane size against the model
    for (int t = 0; t < NT; t++) begin
      for (int ln = 0; ln < 4; ln++) begin
        drive(T_DATA[t], 2'(ln), T_OP[t], T_COUNT[t], T_CLIP[t]);
        m = model(T_DATA[t], ln, int'(T_OP[t]), int'(T_COUNT[t]), T_CLIP[t]);
        check("R2 valid", {127'd0, out_valid}, 128'd1);
        check("R3-R10 table data", out_data, m[127:0]);
        check("R10 flag", {127'd0, out_illegal}, {127'd0, m[128]});
      end
    end

    // R3: byte left by 1, no carry into the next byte
    drive({16{8'h81}}, 2'd0, 3'd0, 8'd1, 1'b0);
    check("R3", out_data, {16{8'h02}});
    // R3: halfword lanes
    drive({16{8'h81}}, 2'd1, 3'd0, 8'd4, 1'b0);
    check("R3", out_data, {8{16'h1810}});
    // R4: doubleword right by 63
    drive({128{1'b1}}, 2'd3, 3'd1, 8'd63, 1'b0);
    check("R4", out_data, {2{64'h1}});
    // R8: byte clip, count 9 acts as 1
    drive({16{8'h81}}, 2'd0, 3'd1, 8'd9, 1'b1);
    check("R8", out_data, {16{8'h40}});
    // R8: byte clip, count 8 acts as 0
    drive(D1, 2'd0, 3'd0, 8'd8, 1'b1);
    check("R8", out_data, D1);
    // R6: byte saturate with clip off
    drive({16{8'h81}}, 2'd0, 3'd1, 8'd9, 1'b0);
    check("R6", out_data, 128'd0);
    // R8: clip ignored for halfword lanes
    drive({16{8'h81}}, 2'd1, 3'd0, 8'd9, 1'b1);
    check("R8", out_data, {8{16'h0200}});
    // R5: halfword arithmetic right
    drive({8{16'h8000}}, 2'd1, 3'd2, 8'd4, 1'b0);
    check("R5", out_data, {8{16'hF800}});
    // R7: word arithmetic over range
    drive({2{32'h80000001, 32'h7FFFFFFF}}, 2'd2, 3'd2, 8'd40, 1'b0);
    check("R7", out_data, {2{32'hFFFFFFFF, 32'h0}});
    // R9: whole-operand byte moves
    drive(128'h0102030405060708090A0B0C0D0E0F10, 2'd2, 3'd3, 8'd1, 1'b0);
    check("R9", out_data, 128'h02030405060708090A0B0C0D0E0F1000);
    drive(128'h0102030405060708090A0B0C0D0E0F10, 2'd0, 3'd4, 8'd2, 1'b0);
    check("R9", out_data, 128'h00000102030405060708090A0B0C0D0E);
    drive(D1, 2'd1, 3'd3, 8'd16, 1'b0);
    check("R9", out_data, 128'd0);
    // R10: illegal requests pass through and flag
    drive(D2, 2'd3, 3'd2, 8'd3, 1'b0);
    check("R10", out_data, D2);
    check("R10", {127'd0, out_illegal}, 128'd1);
    drive(D1, 2'd1, 3'd7, 8'd3, 1'b0);
    check("R10", out_data, D1);
    check("R10", {127'd0, out_illegal}, 128'd1);
    // R11: count zero on a legal request
    drive(D2, 2'd3, 3'd0, 8'd0, 1'b0);
    check("R11", out_data, D2);
    check("R11", {127'd0, out_illegal}, 128'd0);

    // R2: idle cycles hold the result
    @(negedge clk);
    in_data = D1; in_op = 3'd1; in_count = 8'd4;
    @(negedge clk);
    @(negedge clk);
    check("R2 hold", out_data, D2);
    check("R2 idle", {127'd0, out_valid}, 128'd0);

    finish_run();
  end
endmodule